// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

This block is a watchdog counter that advances on a slow tick pulse delivered in the system clock domain. Software controls it through a single 8-bit control write port. One write can pick one of four timeout lengths and turn the watchdog on. Once the watchdog is running, it cannot be turned off, and its timeout length cannot be changed.

While the watchdog runs, software restarts the count by writing two key values into the upper nibble of the control word. The arming value 0xA comes first, then the firing value 0x5. The firing write only counts if no watchdog tick arrives between the two writes. If the counter reaches the selected number of ticks, the block asserts a reset request for one system clock and starts counting again from zero. A read-back port shows the enable bit and the timeout selection.

Top module: `wdog_keyed_top`

## Requirements
- R1: After synchronous active-low reset, `rd_data` is 0x00, the watchdog is disabled with timeout code 00, and `rst_req` is low.
- R2: While disabled, a write stores `wr_data[1:0]` as the timeout code. `rd_data[1:0]` shows the code and `rd_data[3]` shows the enable bit. All other `rd_data` bits read 0.
- R3: Writing 1 to `wr_data[3]` enables the watchdog. Writing 0 to that bit never disables it.
- R4: While enabled, writes to `wr_data[1:0]` are ignored, and the timeout code keeps its value.
- R5: While enabled, `rst_req` is high for exactly one clock after the N-th tick counted from zero, and the counter then wraps to zero. N is TMO0, TMO1, TMO2 or TMO3 for codes 00, 01, 10 and 11 (defaults 32768, 8192, 512, 64).
- R6: While enabled, writing key nibble `wr_data[7:4]` = 0xA, then 0x5 with no tick in between, loads the counter with zero. A tick in the same cycle as the 0x5 write still allows the restart.
- R7: A tick that arrives after the 0xA write and before the 0x5 write expires the sequence, and the later 0x5 write has no effect.
- R8: Any write whose key nibble is neither 0x5 nor 0xA aborts an armed sequence. A new 0xA write restarts the sequence.
- R9: Key nibble writes are ignored while the watchdog is disabled. Neither an arming write nor a firing write made while disabled carries into the enabled state.
- R10: When a restart and a tick fall in the same cycle, the restart wins. The counter holds zero afterwards, so a full N more ticks are needed before `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle watchdog tick pulse |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 8 | Control write data: key [7:4], enable [3], timeout code [1:0] |
| rd_data | output | 8 | Control read-back: enable [3], timeout code [1:0] |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with timeouts of 24, 16, 8 and 4 ticks instead of the multi-thousand-tick defaults. At these sizes it can sweep every timeout code through its full count and through a second wrap, checking each tick. The short windows also keep the key-sequence scenarios cheap to run: restart, expiry by a tick, abort by a stray nibble, re-arming, and a restart colliding with a tick. Each scenario is placed at a known count, and the expected tick of the next reset request is worked out arithmetically.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int CTRL_W = 8;
    localparam int KEY_W  = 4;

    // Control word layout (software-visible, behaviour depends on it)
    localparam int KEY_LSB  = 4;
    localparam int EN_BIT   = 3;
    localparam int CODE_LSB = 0;
    localparam int CODE_W   = 2;

    localparam logic [KEY_W-1:0] KEY_ARM  = 4'hA;
    localparam logic [KEY_W-1:0] KEY_FIRE = 4'h5;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } ctrl_state_t;

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              en_o,
    output logic [CODE_W-1:0] code_o
);

    ctrl_state_t st_q;
    ctrl_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // timeout code is only writable before the watchdog runs
            if (!st_q.en) begin
                st_d.code = wr_data[CODE_LSB +: CODE_W];
            end
            // enable is set-only
            if (wr_data[EN_BIT]) begin
                st_d.en = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign code_o = st_q.code;

    // R3: once on, the watchdog stays on
    a_r3_enable_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> st_q.en);

    // R4: code frozen while enabled
    a_r4_code_locked : assert property (@(posedge clk) disable iff (!rst_n)
        st_q.en |=> $stable(st_q.code));

endmodule

// File: rtl/wdog_key_fsm.sv
module wdog_key_fsm
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] key_i,
    output logic             restart_o
);

    typedef struct packed {
        key_state_e st;
    } key_regs_t;

    key_regs_t r_q;
    key_regs_t r_d;
    logic      restart_d;

    always_comb begin
        r_d       = r_q;
        restart_d = 1'b0;
        if (!en_i) begin
            r_d.st = KEY_IDLE;
        end else if (wr_en) begin
            if (key_i == KEY_ARM) begin
                r_d.st = KEY_ARMED;
            end else if (key_i == KEY_FIRE && r_q.st == KEY_ARMED) begin
                restart_d = 1'b1;
                r_d.st    = KEY_IDLE;
            end else begin
                r_d.st = KEY_IDLE;
            end
        end else if (tick_i) begin
            // a tick before the firing write closes the window
            r_d.st = KEY_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: KEY_IDLE};
        end else begin
            r_q <= r_d;
        end
    end

    assign restart_o = restart_d;

    // R9: no restart while disabled
    a_r9_no_restart_disabled : assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> en_i);

    // R7: an idle tick closes an armed window
    a_r7_tick_expires : assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == KEY_ARMED && tick_i && !wr_en) |=> r_q.st == KEY_IDLE);

    // R6: a restart only ever follows an armed state
    a_r6_fire_needs_arm : assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> r_q.st == KEY_ARMED);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int TMO0 = 32768,
    parameter int TMO1 = 8192,
    parameter int TMO2 = 512,
    parameter int TMO3 = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              tick_i,
    input  logic              restart_i,
    output logic              req_o
);

    localparam int MAX01 = (TMO0 > TMO1) ? TMO0 : TMO1;
    localparam int MAX23 = (TMO2 > TMO3) ? TMO2 : TMO3;
    localparam int MAX_T = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int NUM_CODES = 1 << CODE_W;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_regs_t;

    cnt_regs_t        r_q;
    cnt_regs_t        r_d;
    logic [CNT_W-1:0] last_val;
    logic [CNT_W-1:0] lim_tab [NUM_CODES];

    generate
        for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
            localparam int T = (g == 0) ? TMO0 : (g == 1) ? TMO1 :
                               (g == 2) ? TMO2 : TMO3;
            assign lim_tab[g] = CNT_W'(T - 1);
        end
    endgenerate

    assign last_val = lim_tab[code_i];

    always_comb begin
        r_d     = r_q;
        r_d.req = 1'b0;
        if (en_i) begin
            if (restart_i) begin
                r_d.cnt = '0;
            end else if (tick_i) begin
                if (r_q.cnt == last_val) begin
                    r_d.cnt = '0;
                    r_d.req = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_o = r_q.req;

    // R5: request is a single-cycle pulse
    a_r5_req_single : assert property (@(posedge clk) disable iff (!rst_n)
        r_q.req |=> !r_q.req);

    // R5: count never passes the selected limit
    a_r5_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= last_val);

    // R10: restart always leaves the counter at zero, tick or not
    a_r10_restart_wins : assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && restart_i) |=> (r_q.cnt == '0 && !r_q.req));

    // R1: nothing moves while disabled
    a_r1_idle_disabled : assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (r_q.cnt == '0 && !r_q.req));

endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
    import wdog_pkg::*;
#(
    parameter int TMO0 = 32768,
    parameter int TMO1 = 8192,
    parameter int TMO2 = 512,
    parameter int TMO3 = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       rst_req
);

    logic              en_w;
    logic [CODE_W-1:0] code_w;
    logic              restart_w;

    wdog_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en_o    (en_w),
        .code_o  (code_w)
    );

    wdog_key_fsm u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .tick_i    (tick),
        .wr_en     (wr_en),
        .key_i     (wr_data[KEY_LSB +: KEY_W]),
        .restart_o (restart_w)
    );

    wdog_counter #(
        .TMO0 (TMO0),
        .TMO1 (TMO1),
        .TMO2 (TMO2),
        .TMO3 (TMO3)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_w),
        .code_i    (code_w),
        .tick_i    (tick),
        .restart_i (restart_w),
        .req_o     (rst_req)
    );

    always_comb begin
        rd_data                         = '0;
        rd_data[EN_BIT]                 = en_w;
        rd_data[CODE_LSB +: CODE_W]     = code_w;
    end

    // R2: reserved read-back bits stay zero
    a_r2_rd_reserved : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:4] == 4'h0) && !rd_data[2]);

endmodule

// File: tb/wdog_keyed_top_test.sv
module wdog_keyed_top_test;

    localparam int T0 = 24;
    localparam int T1 = 16;
    localparam int T2 = 8;
    localparam int T3 = 4;
    localparam int TT [4] = '{T0, T1, T2, T3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rst_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    wdog_keyed_top #(.TMO0(T0), .TMO1(T1), .TMO2(T2), .TMO3(T3)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: drive at negedge, sample at next negedge
    task automatic cyc(input logic w, input logic [7:0] d, input logic t);
        wr_en = w; wr_data = d; tick = t;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // n ticks, request expected only right after tick number at (0 = never)
    task automatic ticks(input string req, input int n, input int at);
        for (int i = 1; i <= n; i++) begin
            cyc(1'b0, 8'h00, 1'b1);
            chk(req, rst_req, (i == at) ? 1 : 0);
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1
        chk("R1", rd_data, 0);
        chk("R1", rst_req, 0);

        // R2 / R3 / R4
        cyc(1'b1, 8'h01, 1'b0);
        chk("R2", rd_data, 8'h01);
        cyc(1'b1, 8'hF3, 1'b0);
        chk("R2", rd_data, 8'h03);
        cyc(1'b1, 8'h0A, 1'b0);
        chk("R3", rd_data, 8'h0A);
        cyc(1'b1, 8'h01, 1'b0);
        chk("R4", rd_data, 8'h0A);
        cyc(1'b1, 8'h00, 1'b0);
        chk("R3", rd_data[3], 1);

        // R5: sweep every code over two periods
        for (int c = 0; c < 4; c++) begin
            do_reset();
            chk("R1", rst_req, 0);
            cyc(1'b1, 8'h08 | 8'(c), 1'b0);
            chk("R2", rd_data, 8'h08 | c);
            ticks("R5", TT[c], TT[c]);
            cyc(1'b0, 8'h00, 1'b0);
            chk("R5", rst_req, 0);
            ticks("R5", TT[c], TT[c]);
        end

        // R6: code 10 (8 ticks)
        do_reset();
        cyc(1'b1, 8'h0A, 1'b0);
        ticks("R6", 5, 0);
        cyc(1'b1, 8'hA8, 1'b0);
        cyc(1'b1, 8'h58, 1'b0);
        ticks("R6", 8, 8);

        // R7: tick between keys expires
        ticks("R7", 5, 0);
        cyc(1'b1, 8'hA8, 1'b0);
        ticks("R7", 1, 0);
        cyc(1'b1, 8'h58, 1'b0);
        ticks("R7", 2, 2);

        // R8: stray nibble aborts, then re-arm works
        ticks("R8", 5, 0);
        cyc(1'b1, 8'hA8, 1'b0);
        cyc(1'b1, 8'h38, 1'b0);
        cyc(1'b1, 8'h58, 1'b0);
        ticks("R8", 3, 3);
        ticks("R8", 5, 0);
        cyc(1'b1, 8'hA8, 1'b0);
        cyc(1'b1, 8'hA8, 1'b0);
        cyc(1'b1, 8'h58, 1'b0);
        ticks("R8", 8, 8);

        // R6 / R10: restart colliding with a tick
        ticks("R10", 5, 0);
        cyc(1'b1, 8'hA8, 1'b0);
        cyc(1'b1, 8'h58, 1'b1);
        chk("R10", rst_req, 0);
        ticks("R10", 8, 8);

        // R10 at the limit: restart on what would be the expiring tick
        ticks("R10", 7, 0);
        cyc(1'b1, 8'hA8, 1'b0);
        cyc(1'b1, 8'h58, 1'b1);
        chk("R10", rst_req, 0);
        ticks("R10", 8, 8);

        // R9: keys while disabled leave nothing behind
        do_reset();
        cyc(1'b1, 8'hA2, 1'b0);
        chk("R9", rd_data, 8'h02);
        cyc(1'b1, 8'h5A, 1'b0);
        chk("R9", rd_data, 8'h0A);
        ticks("R9", 5, 0);
        cyc(1'b1, 8'h58, 1'b0);
        ticks("R9", 3, 3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule